// File: doc/BRIEF.md
# Offset-Aware Physical Timer Compare Unit

This block is the per-core compare stage of a physical timer. It takes the free-running 64-bit system count as an input and holds three pieces of state: a counter offset, a compare deadline and a small control word. On every clock edge it subtracts the effective offset from the count, subtracts the deadline from that result, and tests the signed outcome. It records the result in a status bit and raises its interrupt when the status bit is set, the timer is enabled and the interrupt is not masked.

The effective offset is the stored offset unless one of three configuration conditions forces it to zero: the hypervisor's counter-virtualization enable is low, the secure monitor's enable for the feature is low, or the core runs as a host hypervisor (host-OS mode and route-to-hypervisor both set). The same effective offset adjusts counter reads made from the two lowest privilege levels. Reads from privilege level 2 or above see the raw count. The stored offset can always be read and written, whether or not it is currently applied.

A flat register port with a 2-bit address reaches the offset, the deadline, the control word and the adjusted counter view.

Top module: `offs_timer_cmp`

## Requirements
- R1: The status bit is set by the clock edge after the cycle in which (count - effective offset) - deadline, taken modulo 2^64, is zero or positive, and is cleared by the edge after the cycle in which it is negative.
- R2: The sign test uses bit 63 of the modular difference. A count of 0 against a deadline of all ones sets status.
- R3: The effective offset is zero while virt_en_i is 0.
- R4: The effective offset is zero while mon_en_i is 0.
- R5: The effective offset is zero while host_os_i and route_hyp_i are both 1. With host_os_i=1 and route_hyp_i=0 the stored offset applies.
- R6: A read of address 3 returns count minus the effective offset when priv_i is 0 or 1, and the raw count when priv_i is 2 or 3.
- R7: Address 0 holds the stored offset. It is readable and writable whatever the gating inputs are.
- R8: Address 2 is the control word: bit 0 enable (rw), bit 1 mask (rw), bit 2 status (ro), all other bits read 0. irq_o equals status AND enable AND NOT mask.
- R9: A write to address 2 does not change the status bit.
- R10: After reset the offset, the deadline, enable, mask and status are all 0, and irq_o is 0.
- R11: A write to address 0 or 1 captured at clock edge k is reflected in status and irq_o after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | System count |
| priv_i | input | 2 | Privilege level of the current access |
| virt_en_i | input | 1 | Hypervisor counter-virtualization enable |
| mon_en_i | input | 1 | Secure monitor enable for offset use |
| host_os_i | input | 1 | Hypervisor runs a host OS in its own level |
| route_hyp_i | input | 1 | Lower-level traps routed to hypervisor |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 offset, 1 deadline, 2 control, 3 counter view |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i (combinational) |
| irq_o | output | 1 | Timer interrupt |

## Verification
The bench builds the block with its default 64-bit count width. At that width the sign bit of the difference sits at bit 63, so vectors can place the count, the offset and the deadline on both sides of the 2^64 wrap and of the signed midpoint. This separates a correct signed test from a plain unsigned compare and from an offset that is added rather than subtracted. Each gating condition is changed on its own against a difference of -1, so that the status bit flips only when the offset is dropped.

// File: rtl/offs_timer_pkg.sv
package offs_timer_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_OFFSET = 2'd0,
    A_DEADLN = 2'd1,
    A_CTRL   = 2'd2,
    A_CNTVW  = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MASK_BIT = 1;
  localparam int CTRL_STAT_BIT = 2;

  // levels below this one see the offset-adjusted count
  localparam logic [1:0] HYP_LEVEL = 2'd2;
endpackage

// File: rtl/offs_gate.sv
module offs_gate #(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] off_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_en_i,
  input  logic             mon_en_i,
  input  logic             host_os_i,
  input  logic             route_hyp_i,
  output logic [CNT_W-1:0] eff_off_o,
  output logic [CNT_W-1:0] cnt_view_o
);
  import offs_timer_pkg::*;

  logic apply_off;
  logic host_mode;

  assign host_mode = host_os_i & route_hyp_i;
  assign apply_off = virt_en_i & mon_en_i & ~host_mode;
  assign eff_off_o = apply_off ? off_i : '0;

  always_comb begin
    if (priv_i < HYP_LEVEL) cnt_view_o = cnt_i - eff_off_o;
    else                    cnt_view_o = cnt_i;
  end
endmodule

// File: rtl/offs_regs.sv
module offs_regs #(
  parameter int CNT_W = 64
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [offs_timer_pkg::ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]                    wdata_i,
  output logic [CNT_W-1:0]                    off_o,
  output logic [CNT_W-1:0]                    dl_o,
  output logic                                en_o,
  output logic                                mask_o
);
  import offs_timer_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o  <= '0;
      dl_o   <= '0;
      en_o   <= 1'b0;
      mask_o <= 1'b0;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(addr_i))
        A_OFFSET: off_o <= wdata_i;
        A_DEADLN: dl_o  <= wdata_i;
        A_CTRL: begin
          en_o   <= wdata_i[CTRL_EN_BIT];
          mask_o <= wdata_i[CTRL_MASK_BIT];
        end
        default: ;
      endcase
    end
  end

  p_off_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_OFFSET) |=> off_o == $past(wdata_i));

  p_ctrl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_CTRL) |=> $stable(en_o) && $stable(mask_o));
endmodule

// File: rtl/offs_cmp.sv
module offs_cmp #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] eff_off_i,
  input  logic [CNT_W-1:0] dl_i,
  input  logic             en_i,
  input  logic             mask_i,
  output logic             status_o,
  output logic             irq_o
);
  localparam int SIGN_BIT = CNT_W - 1;

  logic [CNT_W-1:0] gap;
  assign gap = (cnt_i - eff_off_i) - dl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= 1'b0;
    else         status_o <= ~gap[SIGN_BIT];
  end

  assign irq_o = status_o & en_i & ~mask_i;

  p_zero_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i - eff_off_i) == dl_i) |=> status_o);

  p_one_short_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i - eff_off_i) + 1'b1 == dl_i) |=> !status_o);

  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i || !en_i) |-> !irq_o);
endmodule

// File: rtl/offs_timer_cmp.sv
module offs_timer_cmp #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_en_i,
  input  logic             mon_en_i,
  input  logic             host_os_i,
  input  logic             route_hyp_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  import offs_timer_pkg::*;

  logic [CNT_W-1:0] off_q, dl_q, eff_off, cnt_view;
  logic             en_q, mask_q, status;

  offs_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .off_o   (off_q),
    .dl_o    (dl_q),
    .en_o    (en_q),
    .mask_o  (mask_q)
  );

  offs_gate #(.CNT_W(CNT_W)) u_gate (
    .off_i       (off_q),
    .cnt_i       (cnt_i),
    .priv_i      (priv_i),
    .virt_en_i   (virt_en_i),
    .mon_en_i    (mon_en_i),
    .host_os_i   (host_os_i),
    .route_hyp_i (route_hyp_i),
    .eff_off_o   (eff_off),
    .cnt_view_o  (cnt_view)
  );

  offs_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_i),
    .eff_off_i (eff_off),
    .dl_i      (dl_q),
    .en_i      (en_q),
    .mask_i    (mask_q),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      A_OFFSET: rdata_o = off_q;
      A_DEADLN: rdata_o = dl_q;
      A_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = en_q;
        rdata_o[CTRL_MASK_BIT] = mask_q;
        rdata_o[CTRL_STAT_BIT] = status;
      end
      A_CNTVW: rdata_o = cnt_view;
      default: ;
    endcase
  end

  p_gate_virt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !virt_en_i |-> eff_off == '0);

  p_gate_mon_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i |-> eff_off == '0);

  p_gate_host_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_os_i && route_hyp_i) |-> eff_off == '0);

  p_raw_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CNTVW && priv_i >= HYP_LEVEL) |-> rdata_o == cnt_i);

  p_status_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL) |=> status == $past(~(((cnt_i - eff_off) - dl_q) >> (CNT_W-1)) & 1'b1));
endmodule

// File: tb/offs_timer_cmp_tb.sv
`timescale 1ns/1ps
module offs_timer_cmp_tb;
  localparam int W = 64;

  typedef struct packed {
    logic [W-1:0] cnt;
    logic [W-1:0] off;
    logic [W-1:0] dl;
    logic         virt;
    logic         mon;
    logic         host;
    logic         route;
    logic         exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{64'd1000, 64'd100, 64'd900, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R1 equal
    '{64'd1000, 64'd101, 64'd900, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 minus one
    '{64'd1000, 64'd101, 64'd900, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R3
    '{64'd1000, 64'd101, 64'd900, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R4
    '{64'd1000, 64'd101, 64'd900, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},  // R5 host pair
    '{64'd1000, 64'd101, 64'd900, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 half pair
    '{64'd5, 64'd10, 64'hFFFF_FFFF_FFFF_FFFB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 wrap
    '{64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 signed
    '{64'd0, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}   // R2 midpoint
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic [1:0]   priv = 2'd1;
  logic         virt = 1'b1, mon = 1'b1, host = 1'b0, route = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  offs_timer_cmp #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .priv_i(priv),
    .virt_en_i(virt), .mon_en_i(mon), .host_os_i(host), .route_hyp_i(route),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    // R10 reset state
    rd(2'd0, r); chk("R10 offset", r, '0);
    rd(2'd1, r); chk("R10 deadline", r, '0);
    rd(2'd2, r); chk("R10 ctrl", r, '0);
    chk("R10 irq", {63'd0, irq}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'd2, 64'd1);  // enable, unmasked

    for (int i = 0; i < NV; i++) begin
      cnt = VECS[i].cnt; virt = VECS[i].virt; mon = VECS[i].mon;
      host = VECS[i].host; route = VECS[i].route;
      wr(2'd0, VECS[i].off);
      wr(2'd1, VECS[i].dl);
      @(negedge clk);
      rd(2'd2, r);
      chk($sformatf("R1 vector %0d status", i), {63'd0, r[2]}, {63'd0, VECS[i].exp});
      chk($sformatf("R8 vector %0d irq", i), {63'd0, irq}, {63'd0, VECS[i].exp});
    end

    // R11 timing: deadline write makes condition true
    cnt = 64'd500; virt = 1'b1; mon = 1'b1; host = 1'b0; route = 1'b0;
    wr(2'd0, 64'd0);
    wr(2'd1, 64'd600);
    @(negedge clk);
    chk("R11 settle low", {63'd0, irq}, 64'd0);
    wr(2'd1, 64'd500);  // returns one negedge after capture edge
    chk("R11 not before k+1", {63'd0, irq}, 64'd0);
    @(negedge clk);
    chk("R11 after k+1", {63'd0, irq}, 64'd1);

    // R8 mask suppresses irq while status stays 1
    wr(2'd2, 64'd3);
    rd(2'd2, r);
    chk("R8 masked ctrl", r, 64'd7);
    chk("R8 masked irq", {63'd0, irq}, 64'd0);
    wr(2'd2, 64'd0);
    chk("R8 disabled irq", {63'd0, irq}, 64'd0);

    // R9 status write ignored
    wr(2'd1, 64'd900);
    @(negedge clk);
    wr(2'd2, 64'd5);  // enable + attempt status=1
    @(negedge clk);
    rd(2'd2, r);
    chk("R9 status write ignored", r, 64'd1);
    chk("R9 irq low", {63'd0, irq}, 64'd0);

    // R6 counter view
    cnt = 64'd10_000;
    wr(2'd0, 64'd250);
    priv = 2'd1; rd(2'd3, r); chk("R6 level1 view", r, 64'd9750);
    priv = 2'd0; rd(2'd3, r); chk("R6 level0 view", r, 64'd9750);
    priv = 2'd2; rd(2'd3, r); chk("R6 level2 raw", r, 64'd10_000);
    priv = 2'd3; rd(2'd3, r); chk("R6 level3 raw", r, 64'd10_000);
    priv = 2'd1; virt = 1'b0;
    rd(2'd3, r); chk("R6 R3 gated view", r, 64'd10_000);
    virt = 1'b1; host = 1'b1; route = 1'b1;
    rd(2'd3, r); chk("R6 R5 host view", r, 64'd10_000);

    // R7 offset access while gated
    mon = 1'b0;
    wr(2'd0, 64'hDEAD_BEEF_0123_4567);
    rd(2'd0, r); chk("R7 offset rw while gated", r, 64'hDEAD_BEEF_0123_4567);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule